// File: doc/BRIEF.md
# PS/2 Device-to-Host Frame Receiver

This block takes the open-drain clock and data lines of a PS/2 keyboard or mouse and turns each 11-bit frame sent by the device into one byte. Both lines pass through a two-flop synchroniser. A software-set divider produces a sample tick of about 3 µs. The clock line counts as a valid level only when two consecutive ticks see the same value, and each filtered falling edge of that clock samples the data line.

The receiver never drives the bus. Both pin outputs stay at 1, which releases the lines so they float high. Each frame ends in exactly one of four one-cycle strobes: byte valid (with the byte on a data bus), parity error, framing error or timeout. An error frame delivers no byte.

The frame tracker has four states. In `RX_IDLE` a falling edge records the start bit and moves to `RX_DATA`. In `RX_DATA` each edge shifts in one data bit, LSB first. After the eighth bit the tracker moves to `RX_PARITY`. There one edge captures the parity bit and moves to `RX_STOP`. In `RX_STOP` one edge judges the frame and returns to `RX_IDLE`. From any state except `RX_IDLE`, an expired edge timer returns to `RX_IDLE`.

Top module: `ps2_rx_frame`

## Requirements
- R1: `kbd_clk_out` and `kbd_dat_out` are 1 at every cycle, in reset and in operation.
- R2: A frame that has start 0, data D0..D7 (sent LSB first), a parity bit that makes the nine bits odd, and stop 1 gives a `byte_vld` pulse of exactly one cycle. `byte_data` equals D7..D0 during that pulse and changes only in the cycle `byte_vld` is raised.
- R3: A frame whose start and stop bits are correct but whose parity count is even gives one `parity_err` pulse and no `byte_vld`.
- R4: A frame whose start bit is 1 gives one `frame_err` pulse at its stop edge and no `byte_vld`.
- R5: A frame whose stop bit is 0 gives one `frame_err` pulse and no `byte_vld`. If the same frame also fails parity, only `frame_err` is raised.
- R6: After a frame has started, if `TO_TICKS` (default 40) ticks pass with no filtered falling edge, one `timeout_err` pulse is raised and the tracker returns to `RX_IDLE`. The next complete frame is then received correctly.
- R7: A low pulse on the PS/2 clock that is shorter than one tick produces no strobe and does not disturb the next frame.
- R8: One tick lasts `tick_div` system clocks. The timeout interval therefore scales with `tick_div`: at 5 it is about 200 cycles, at 20 about 800 cycles.
- R9: After reset all four strobes and `byte_data` are 0.
- R10: At most one of the four strobes is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div | input | 16 | System clocks per sample tick (0 treated as 1) |
| kbd_clk_in | input | 1 | PS/2 clock line as seen at the pad |
| kbd_dat_in | input | 1 | PS/2 data line as seen at the pad |
| kbd_clk_out | output | 1 | PS/2 clock drive, 1 = release, 0 = pull low |
| kbd_dat_out | output | 1 | PS/2 data drive, 1 = release, 0 = pull low |
| byte_vld | output | 1 | One-cycle strobe: `byte_data` holds a good byte |
| byte_data | output | 8 | Received byte |
| parity_err | output | 1 | One-cycle strobe: parity mismatch |
| frame_err | output | 1 | One-cycle strobe: bad start or stop bit |
| timeout_err | output | 1 | One-cycle strobe: frame stalled |

## Verification
Two checks can fall in the same cycle: the stop-bit check and the parity check both run on the final falling edge. A vector that sends stop 0 together with inverted parity tests this case. The check passes if the counted `frame_err` pulses rise by one while the `parity_err` and `byte_vld` counts stay the same. A last clock edge and the expiry of the edge timer can also meet in one tick. In that case the edge must win, and the timeout tests judge this through the measured delay from the last edge to the `timeout_err` pulse.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_DATA   = 2'd1,
        RX_PARITY = 2'd2,
        RX_STOP   = 2'd3
    } rx_state_t;

    typedef enum logic [1:0] {
        VERDICT_GOOD   = 2'd0,
        VERDICT_PARITY = 2'd1,
        VERDICT_FRAME  = 2'd2
    } verdict_t;

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Lines idle high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ps2rx_tick.sv
module ps2rx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // A divider of 0 behaves as 1: one tick per cycle.
    assign limit = (div == '0) ? '0 : div - 1'b1;
    assign tick  = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ps2rx_filter.sv
module ps2rx_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl_in,
    output logic fall
);
    logic prev_smp_q;
    logic filt_q;
    logic agree;

    assign agree = (lvl_in == prev_smp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_smp_q <= 1'b1;
            filt_q     <= 1'b1;
            fall       <= 1'b0;
        end else begin
            fall <= 1'b0;
            if (tick) begin
                prev_smp_q <= lvl_in;
                if (agree) begin
                    filt_q <= lvl_in;
                    fall   <= filt_q & ~lvl_in;
                end
            end
        end
    end
endmodule

// File: rtl/ps2rx_timeout.sv
module ps2rx_timeout #(
    parameter int TO_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic edge_seen,
    output logic expire
);
    localparam int CW = $clog2(TO_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // An edge in the same cycle always wins over expiry.
    assign expire = active && tick && !edge_seen && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (!active || edge_seen)  cnt_q <= '0;
        else if (tick && !expire)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
    import ps2rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 8,
    parameter int TO_TICKS    = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  tick_div,
    input  logic              kbd_clk_in,
    input  logic              kbd_dat_in,
    output logic              kbd_clk_out,
    output logic              kbd_dat_out,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              parity_err,
    output logic              frame_err,
    output logic              timeout_err
);
    localparam int BCW = $clog2(DATA_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

    logic [1:0]        line_sync;
    logic              clk_s, dat_s;
    logic              tick, fall, expire;
    rx_state_t         state, state_nx;
    logic [DATA_W-1:0] shreg_q;
    logic [BCW-1:0]    bit_cnt_q;
    logic              start_q, par_q;
    verdict_t          verdict;

    // Receive only: never pull either line.
    assign kbd_clk_out = 1'b1;
    assign kbd_dat_out = 1'b1;

    ps2rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({kbd_clk_in, kbd_dat_in}), .sync_out(line_sync)
    );
    assign clk_s = line_sync[1];
    assign dat_s = line_sync[0];

    ps2rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(tick_div), .tick(tick)
    );

    ps2rx_filter u_filter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lvl_in(clk_s), .fall(fall)
    );

    ps2rx_timeout #(.TO_TICKS(TO_TICKS)) u_timeout (
        .clk(clk), .rst_n(rst_n), .active(state != RX_IDLE),
        .tick(tick), .edge_seen(fall), .expire(expire)
    );

    // Framing outranks parity.
    always_comb begin
        if (start_q || !dat_s)        verdict = VERDICT_FRAME;
        else if (!(^{shreg_q, par_q})) verdict = VERDICT_PARITY;
        else                           verdict = VERDICT_GOOD;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (fall) state_nx = RX_DATA;
            RX_DATA:   if (expire) state_nx = RX_IDLE;
                       else if (fall && bit_cnt_q == LAST_BIT) state_nx = RX_PARITY;
            RX_PARITY: if (expire) state_nx = RX_IDLE;
                       else if (fall) state_nx = RX_STOP;
            RX_STOP:   if (expire || fall) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    // State register with frame datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            start_q   <= 1'b0;
            par_q     <= 1'b0;
        end else begin
            state <= state_nx;
            if (fall) begin
                unique case (state)
                    RX_IDLE: begin
                        start_q   <= dat_s;
                        bit_cnt_q <= '0;
                    end
                    RX_DATA: begin
                        shreg_q   <= {dat_s, shreg_q[DATA_W-1:1]};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                    RX_PARITY: par_q <= dat_s;
                    RX_STOP:   ;
                    default:   ;
                endcase
            end
        end
    end

    // Output strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_vld    <= 1'b0;
            byte_data   <= '0;
            parity_err  <= 1'b0;
            frame_err   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            byte_vld    <= 1'b0;
            parity_err  <= 1'b0;
            frame_err   <= 1'b0;
            timeout_err <= expire;
            if (state == RX_STOP && fall) begin
                unique case (verdict)
                    VERDICT_FRAME:  frame_err  <= 1'b1;
                    VERDICT_PARITY: parity_err <= 1'b1;
                    VERDICT_GOOD: begin
                        byte_vld  <= 1'b1;
                        byte_data <= shreg_q;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ps2_rx_frame_chk.sv
module ps2_rx_frame_chk
    import ps2rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kbd_clk_out,
    input logic              kbd_dat_out,
    input logic              byte_vld,
    input logic [DATA_W-1:0] byte_data,
    input logic              parity_err,
    input logic              frame_err,
    input logic              timeout_err,
    input rx_state_t         state
);
    // R1
    pins_released_chk: assert property (@(posedge clk)
        kbd_clk_out && kbd_dat_out);

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({byte_vld, parity_err, frame_err, timeout_err}) <= 1);

    // R2
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_data) |-> byte_vld);

    // R6
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> state == RX_IDLE);

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err || frame_err || timeout_err) |=> !(parity_err || frame_err || timeout_err));
endmodule

bind ps2_rx_frame ps2_rx_frame_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .kbd_clk_out(kbd_clk_out), .kbd_dat_out(kbd_dat_out),
    .byte_vld(byte_vld), .byte_data(byte_data), .parity_err(parity_err),
    .frame_err(frame_err), .timeout_err(timeout_err), .state(state)
);

// File: tb/ps2_rx_frame_bench.sv
module ps2_rx_frame_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] tick_div;
    logic        ps_clk, ps_dat;
    logic        clk_out, dat_out, byte_vld, parity_err, frame_err, timeout_err;
    logic [7:0]  byte_data;

    always #10 clk = ~clk;

    ps2_rx_frame u_ps2_rx_frame (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div),
        .kbd_clk_in(ps_clk), .kbd_dat_in(ps_dat),
        .kbd_clk_out(clk_out), .kbd_dat_out(dat_out),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .parity_err(parity_err), .frame_err(frame_err), .timeout_err(timeout_err)
    );

    int total = 0, bad = 0;
    int n_vld = 0, n_par = 0, n_frm = 0, n_to = 0, n_long = 0, n_multi = 0, n_pin = 0;
    longint cyc = 0, to_time = 0;
    logic [7:0] last_data = 8'h00;
    logic prev_any = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!(clk_out && dat_out)) n_pin++;
        if (rst_n) begin
            if (byte_vld) begin n_vld++; last_data = byte_data; end
            if (parity_err) n_par++;
            if (frame_err) n_frm++;
            if (timeout_err) begin n_to++; to_time = cyc; end
            if ((byte_vld + parity_err + frame_err + timeout_err) > 1) n_multi++;
            if (prev_any && (byte_vld || parity_err || frame_err || timeout_err)) n_long++;
            prev_any = byte_vld || parity_err || frame_err || timeout_err;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic st, input logic flip,
                              input logic sp, input int half);
        logic [10:0] bits;
        bits = {sp, (~^d) ^ flip, d, st};
        for (int i = 0; i < 11; i++) begin
            ps_dat = bits[i];
            repeat (half) @(negedge clk);
            ps_clk = 1'b0;
            repeat (half) @(negedge clk);
            ps_clk = 1'b1;
        end
        ps_dat = 1'b1;
        repeat (4 * half) @(negedge clk);
    endtask

    // Sends start plus three bits, then stalls; returns cycle of last falling edge.
    task automatic stall_frame(input int half, output longint last_fall);
        last_fall = 0;
        for (int i = 0; i < 4; i++) begin
            ps_dat = (i == 0) ? 1'b0 : 1'b1;
            repeat (half) @(negedge clk);
            ps_clk = 1'b0;
            last_fall = cyc;
            repeat (half) @(negedge clk);
            ps_clk = 1'b1;
        end
        ps_dat = 1'b1;
    endtask

    // {kind[1:0], stop, flip, start, data[7:0]}; kind 0 good, 1 parity, 2 frame
    localparam logic [12:0] VEC [9] = '{
        {2'd0, 1'b1, 1'b0, 1'b0, 8'hA5},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'h00},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'hFF},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'h01},
        {2'd1, 1'b1, 1'b1, 1'b0, 8'h80},
        {2'd2, 1'b1, 1'b0, 1'b1, 8'h3C},
        {2'd2, 1'b0, 1'b0, 1'b0, 8'h5A},
        {2'd2, 1'b0, 1'b1, 1'b0, 8'hC3},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'h7E}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_up();
    end

    initial begin
        int v0, p0, f0, t0;
        longint lf;
        rst_n = 1'b0; tick_div = 16'd5; ps_clk = 1'b1; ps_dat = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!byte_vld && !parity_err && !frame_err && !timeout_err, "R9 strobes",
            {byte_vld, parity_err, frame_err, timeout_err}, 0);
        chk(byte_data == 8'h00, "R9 data", byte_data, 0);
        chk(clk_out && dat_out, "R1 pins in reset", {clk_out, dat_out}, 3);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2 R3 R4 R5 vector walk
        foreach (VEC[k]) begin
            v0 = n_vld; p0 = n_par; f0 = n_frm; t0 = n_to;
            send_frame(VEC[k][7:0], VEC[k][8], VEC[k][9], VEC[k][10], 50);
            chk(n_vld - v0 == (VEC[k][12:11] == 2'd0), "R2 vld count", n_vld - v0, VEC[k][12:11] == 2'd0);
            chk(n_par - p0 == (VEC[k][12:11] == 2'd1), "R3 parity count", n_par - p0, VEC[k][12:11] == 2'd1);
            chk(n_frm - f0 == (VEC[k][12:11] == 2'd2), "R4 R5 frame count", n_frm - f0, VEC[k][12:11] == 2'd2);
            chk(n_to == t0, "R6 no timeout", n_to - t0, 0);
            if (VEC[k][12:11] == 2'd0)
                chk(last_data == VEC[k][7:0], "R2 data", last_data, VEC[k][7:0]);
        end

        // R7 short glitch on clock while idle
        v0 = n_vld; p0 = n_par; f0 = n_frm; t0 = n_to;
        ps_clk = 1'b0; repeat (3) @(negedge clk); ps_clk = 1'b1;
        repeat (300) @(negedge clk);
        chk(n_vld + n_par + n_frm + n_to == v0 + p0 + f0 + t0, "R7 glitch silent",
            n_vld + n_par + n_frm + n_to, v0 + p0 + f0 + t0);
        send_frame(8'h96, 1'b0, 1'b0, 1'b1, 50);
        chk(last_data == 8'h96 && n_vld == v0 + 1, "R7 next frame", last_data, 8'h96);
        chk(n_to == t0, "R7 no timeout", n_to - t0, 0);

        // R6 R8 timeout at divider 5
        t0 = n_to; v0 = n_vld;
        stall_frame(50, lf);
        repeat (1000) @(negedge clk);
        chk(n_to == t0 + 1, "R6 timeout count", n_to - t0, 1);
        chk(to_time - lf >= 190 && to_time - lf <= 225, "R8 timeout at div 5", to_time - lf, 200);
        chk(n_vld == v0, "R6 no byte", n_vld - v0, 0);
        send_frame(8'h4D, 1'b0, 1'b0, 1'b1, 50);
        chk(last_data == 8'h4D && n_vld == v0 + 1, "R6 recovers", last_data, 8'h4D);

        // R8 divider 20
        tick_div = 16'd20;
        repeat (100) @(negedge clk);
        t0 = n_to; v0 = n_vld;
        send_frame(8'h2B, 1'b0, 1'b0, 1'b1, 100);
        chk(last_data == 8'h2B && n_vld == v0 + 1, "R8 frame at div 20", last_data, 8'h2B);
        stall_frame(100, lf);
        repeat (1500) @(negedge clk);
        chk(n_to == t0 + 1, "R8 timeout count", n_to - t0, 1);
        chk(to_time - lf >= 760 && to_time - lf <= 870, "R8 timeout at div 20", to_time - lf, 800);

        // R10 R1 global
        chk(n_multi == 0, "R10 overlap", n_multi, 0);
        chk(n_long == 0, "R10 pulse width", n_long, 0);
        chk(n_pin == 0, "R1 pins released", n_pin, 0);
        finish_up();
    end
endmodule